// File: doc/BRIEF.md
# Evicted Dirty Line Holding Buffer

This block sits beside a write-back cache controller and holds one dirty line that has just been chosen for replacement. The controller hands it the line's upper address bits and the four data words in a single cycle, then proceeds with fetching the replacement line from memory. The memory write port stays quiet until the controller reports that the fetch has finished. Replacement fetches therefore always reach memory ahead of the write-back traffic.

Once the fetch is done, the buffer sends the line out one word per valid/ready handshake, lowest word first. The cache remains free for normal hits during this time, because the buffer owns its own copy of the data. A full flag tells the controller whether a further dirty eviction can be accepted. A draining flag tells it that memory write traffic is in progress.

Top module: `evict_line_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `buf_full`, `buf_busy` and `mem_valid` are all 0.
- R2: A `ld_valid` pulse while empty captures `ld_tag` and the four words of `ld_data` (word k in bits 32k+31..32k), and `buf_full` reads 1 from the next cycle on.
- R3: While a loaded line waits for the fetch to complete, `mem_valid` and `buf_busy` stay 0.
- R4: The cycle after `fill_done` is seen with a line held (including `fill_done` in the same cycle as the load), `mem_valid` is 1.
- R5: The k-th write sent carries address {tag, k[1:0], 2'b00} and data word k, for k = 0, 1, 2, 3 in ascending order.
- R6: While `mem_ready` is 0, `mem_valid` stays 1 and address and data stay unchanged; the word advances only on an accepted handshake.
- R7: After the fourth handshake is accepted, `buf_full`, `buf_busy` and `mem_valid` read 0 in the next cycle.
- R8: A `ld_valid` while `buf_full` is 1, including in the cycle of the last handshake, is ignored: the buffered address and words are unchanged, and no new line is held afterwards.
- R9: `fill_done` while the buffer is empty is ignored and not remembered: a later load still waits for its own `fill_done`.
- R10: `buf_busy` is 1 exactly while writes are being offered, and `mem_valid` is never 1 unless `buf_full` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request for an evicted dirty line |
| ld_tag | input | 28 | Line address bits 31..4 |
| ld_data | input | 128 | Four line words, word k at bits 32k+31..32k |
| fill_done | input | 1 | Replacement line fetch has completed |
| mem_valid | output | 1 | A write word is offered to memory |
| mem_ready | input | 1 | Memory accepts the offered word |
| mem_addr | output | 32 | Byte address of the offered word |
| mem_data | output | 32 | Offered data word |
| buf_full | output | 1 | A line is held and not yet fully written |
| buf_busy | output | 1 | Write-back traffic is in progress |

## Verification
The two events that can fall in the same cycle are a line load and the fetch-complete indication. A second pair is a load attempt and the final accepted write word. The sweep puts `fill_done` in the load cycle (zero delay) and also one to three cycles later. It expects the first write offer exactly one cycle after `fill_done`, and no offer before that. In half the cases it drives a conflicting load during the hold, during drain and in the cycle of the fourth accept. Correct handling is judged from every following address and data word, and from `buf_full` reading 0 after the drain.

// File: rtl/evb_pkg.sv
package evb_pkg;

    localparam int EVB_ADDR_W = 32;
    localparam int EVB_DATA_W = 32;
    localparam int EVB_WORDS  = 4;

    typedef enum logic [1:0] {
        EVB_EMPTY = 2'd0,
        EVB_HOLD  = 2'd1,
        EVB_DRAIN = 2'd2
    } evb_state_e;

    typedef struct packed {
        logic full;
        logic draining;
    } evb_status_t;

    function automatic evb_state_e evb_next(
        input evb_state_e cur,
        input logic       take,
        input logic       fill,
        input logic       last_acc
    );
        evb_state_e nxt;
        nxt = cur;
        case (cur)
            EVB_EMPTY: if (take) nxt = fill ? EVB_DRAIN : EVB_HOLD;
            EVB_HOLD:  if (fill) nxt = EVB_DRAIN;
            EVB_DRAIN: if (last_acc) nxt = EVB_EMPTY;
            default:   nxt = EVB_EMPTY;
        endcase
        return nxt;
    endfunction

    function automatic evb_status_t evb_status(input evb_state_e st);
        evb_status_t s;
        s.full     = (st != EVB_EMPTY);
        s.draining = (st == EVB_DRAIN);
        return s;
    endfunction

endpackage

// File: rtl/evb_ctrl.sv
module evb_ctrl
    import evb_pkg::*;
#(
    parameter int WORDS = EVB_WORDS,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_valid,
    input  logic             fill_done,
    input  logic             mem_ready,
    output logic             ld_take,
    output logic [IDX_W-1:0] word_idx,
    output evb_status_t      status
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    evb_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;
    logic             last_acc;

    assign status   = evb_status(state_q);
    assign ld_take  = ld_valid && (state_q == EVB_EMPTY);
    assign accept   = status.draining && mem_ready;
    assign last_acc = accept && (idx_q == LAST_IDX);
    assign word_idx = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= EVB_EMPTY;
        end else begin
            state_q <= evb_next(state_q, ld_take, fill_done, last_acc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ld_take) begin
            idx_q <= '0;
        end else if (accept) begin
            idx_q <= last_acc ? '0 : idx_q + 1'b1;
        end
    end

    AST_NO_EARLY_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (state_q == EVB_HOLD && !fill_done) |=> !status.draining); // R3

    AST_STALL_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
        (status.draining && !mem_ready) |=> (status.draining && $stable(idx_q))); // R6

    AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        ld_take |=> status.full); // R2

    AST_LAST_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        last_acc |=> !status.full); // R7

endmodule

// File: rtl/evb_store.sv
module evb_store #(
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_take,
    input  logic [TAG_W-1:0]        ld_tag,
    input  logic [WORDS*DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]        word_idx,
    output logic [TAG_W-1:0]        tag,
    output logic [DATA_W-1:0]       word
);

    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] words_q [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if (ld_take) begin
            tag_q <= ld_tag;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words_q[g] <= '0;
            end else if (ld_take) begin
                words_q[g] <= ld_data[g*DATA_W +: DATA_W];
            end
        end
    end

    assign tag  = tag_q;
    assign word = words_q[word_idx];

    AST_TAG_KEPT: assert property (@(posedge clk) disable iff (rst)
        !ld_take |=> $stable(tag_q)); // R8

endmodule

// File: rtl/evict_line_buffer.sv
module evict_line_buffer
    import evb_pkg::*;
#(
    parameter int ADDR_W = EVB_ADDR_W,
    parameter int DATA_W = EVB_DATA_W,
    parameter int WORDS  = EVB_WORDS,
    localparam int BYTES   = DATA_W / 8,
    localparam int BYTE_SH = $clog2(BYTES),
    localparam int IDX_W   = $clog2(WORDS),
    localparam int TAG_W   = ADDR_W - IDX_W - BYTE_SH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_valid,
    input  logic [TAG_W-1:0]        ld_tag,
    input  logic [WORDS*DATA_W-1:0] ld_data,
    input  logic                    fill_done,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_data,
    output logic                    buf_full,
    output logic                    buf_busy
);

    logic             ld_take;
    logic [IDX_W-1:0] word_idx;
    logic [TAG_W-1:0] tag;
    evb_status_t      status;

    evb_ctrl #(
        .WORDS(WORDS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .fill_done(fill_done),
        .mem_ready(mem_ready),
        .ld_take  (ld_take),
        .word_idx (word_idx),
        .status   (status)
    );

    evb_store #(
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .WORDS (WORDS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .ld_take (ld_take),
        .ld_tag  (ld_tag),
        .ld_data (ld_data),
        .word_idx(word_idx),
        .tag     (tag),
        .word    (mem_data)
    );

    assign mem_addr  = {tag, word_idx, {BYTE_SH{1'b0}}};
    assign mem_valid = status.draining;
    assign buf_busy  = status.draining;
    assign buf_full  = status.full;

    AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> buf_full); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && word_idx != IDX_W'(WORDS - 1))
        |=> (mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(BYTES))); // R5

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_data))); // R6

endmodule

// File: tb/evict_line_buffer_test.sv
module evict_line_buffer_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         ld_valid;
    logic [27:0]  ld_tag;
    logic [127:0] ld_data;
    logic         fill_done;
    logic         mem_valid;
    logic         mem_ready;
    logic [31:0]  mem_addr;
    logic [31:0]  mem_data;
    logic         buf_full;
    logic         buf_busy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    evict_line_buffer uut (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_tag   (ld_tag),
        .ld_data  (ld_data),
        .fill_done(fill_done),
        .mem_valid(mem_valid),
        .mem_ready(mem_ready),
        .mem_addr (mem_addr),
        .mem_data (mem_data),
        .buf_full (buf_full),
        .buf_busy (buf_busy)
    );

    function automatic logic [31:0] exp_word(input logic [27:0] t, input int k);
        return ({4'h0, t} * 32'h0000_9E37) ^ (32'(k) * 32'h0101_0101) ^ 32'h5A00_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic junk_load(input logic [27:0] t);
        ld_valid = 1'b1;
        ld_tag   = ~t;
        ld_data  = {4{32'hDEAD_BEEF}};
    endtask

    task automatic run_case(input logic [27:0] t, input int delay,
                            input int stall, input bit intrude);
        string rq;
        rq = intrude ? "R8" : "R5";
        @(negedge clk);
        ld_valid  = 1'b1;
        ld_tag    = t;
        for (int k = 0; k < 4; k++) ld_data[k*32 +: 32] = exp_word(t, k);
        fill_done = (delay == 0);
        @(negedge clk);
        ld_valid  = 1'b0;
        fill_done = 1'b0;
        chk(buf_full == 1'b1, "R2", "full after load", 64'(buf_full), 64'd1);
        chk(mem_valid == (delay == 0), "R4", "valid after load",
            64'(mem_valid), 64'(delay == 0));
        for (int d = 1; d <= delay; d++) begin
            chk(mem_valid == 1'b0, "R3", "valid while waiting", 64'(mem_valid), 64'd0);
            chk(buf_busy == 1'b0, "R3", "busy while waiting", 64'(buf_busy), 64'd0);
            fill_done = (d == delay);
            if (intrude && d == 1) junk_load(t);
            @(negedge clk);
            ld_valid  = 1'b0;
            fill_done = 1'b0;
        end
        chk(mem_valid == 1'b1, "R4", "valid after fill", 64'(mem_valid), 64'd1);
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < stall; s++) begin
                mem_ready = 1'b0;
                chk(mem_valid == 1'b1, "R6", "valid in stall", 64'(mem_valid), 64'd1);
                chk(mem_addr == {t, 2'(k), 2'b00}, "R6", "addr in stall",
                    64'(mem_addr), 64'({t, 2'(k), 2'b00}));
                chk(mem_data == exp_word(t, k), "R6", "data in stall",
                    64'(mem_data), 64'(exp_word(t, k)));
                @(negedge clk);
            end
            mem_ready = 1'b1;
            chk(mem_addr == {t, 2'(k), 2'b00}, rq, "addr",
                64'(mem_addr), 64'({t, 2'(k), 2'b00}));
            chk(mem_data == exp_word(t, k), rq, "data",
                64'(mem_data), 64'(exp_word(t, k)));
            chk(buf_busy == 1'b1 && buf_full == 1'b1, "R10", "busy and full in drain",
                64'({buf_busy, buf_full}), 64'd3);
            if (intrude && (k == 1 || k == 3)) junk_load(t);
            @(negedge clk);
            mem_ready = 1'b0;
            ld_valid  = 1'b0;
        end
        chk(buf_full == 1'b0, intrude ? "R8" : "R7", "full after drain", 64'(buf_full), 64'd0);
        chk(mem_valid == 1'b0, "R7", "valid after drain", 64'(mem_valid), 64'd0);
        chk(buf_busy == 1'b0, "R7", "busy after drain", 64'(buf_busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        ld_valid  = 1'b0;
        ld_tag    = '0;
        ld_data   = '0;
        fill_done = 1'b0;
        mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(buf_full == 1'b0, "R1", "full at reset", 64'(buf_full), 64'd0);
        chk(buf_busy == 1'b0, "R1", "busy at reset", 64'(buf_busy), 64'd0);
        chk(mem_valid == 1'b0, "R1", "valid at reset", 64'(mem_valid), 64'd0);

        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
        chk(buf_full == 1'b0, "R9", "full after stray fill", 64'(buf_full), 64'd0);
        chk(mem_valid == 1'b0, "R9", "valid after stray fill", 64'(mem_valid), 64'd0);
        run_case(28'h00A_B0C1, 2, 0, 1'b0);

        for (int ti = 0; ti < 3; ti++) begin
            for (int dl = 0; dl < 4; dl++) begin
                for (int st = 0; st < 3; st++) begin
                    for (int in = 0; in < 2; in++) begin
                        run_case(28'(32'h0123_4567 * (ti + 1) + 32'(dl * 977)), dl, st, in[0]);
                    end
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule